// File: doc/BRIEF.md
# Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit for a processor datapath. It takes two operand words and a 2-bit function code. It returns a result word and three condition flags: signed overflow, zero and carry/borrow. Four functions are available: two arithmetic ones (add, and subtract with the second operand as minuend) and two bitwise ones (AND, XOR).

The block has no clock and no storage. Its outputs follow its inputs after gate delay only. Holding the flags in a condition-code register, and deciding when to update them, is left to the surrounding control logic. The word width is a parameter and defaults to 32 bits.

Top module: `alu_cc`

## Requirements
- R1: With function code 0, the result is (A + B) modulo 2^WIDTH.
- R2: With function code 1, the result is (B - A) modulo 2^WIDTH, so B is the minuend.
- R3: With function code 2, the result is the bitwise AND of A and B. With function code 3, it is the bitwise XOR of A and B.
- R4: The zero flag is 1 exactly when every bit of the result is 0, for every function code.
- R5: For code 0, the carry flag is 1 exactly when the unsigned sum A + B is at least 2^WIDTH.
- R6: For code 1, the carry flag is 1 exactly when B is less than A as unsigned numbers (a borrow).
- R7: For code 0, the overflow flag is 1 exactly when the two's-complement sum of A and B lies outside the signed WIDTH-bit range.
- R8: For code 1, the overflow flag is 1 exactly when the two's-complement difference B - A lies outside the signed WIDTH-bit range.
- R9: For codes 2 and 3, the overflow and carry flags are both 0.
- R10: The outputs depend only on the present inputs. A change of operands or function code shows at the outputs with no clock edge, and the same inputs always give the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 2 | Function code: 0 add, 1 subtract (B - A), 2 AND, 3 XOR |
| opnd_a | input | WIDTH | First operand (subtrahend for code 1) |
| opnd_b | input | WIDTH | Second operand (minuend for code 1) |
| result | output | WIDTH | Function result |
| flag_ovf | output | 1 | Two's-complement overflow; 0 for bitwise codes |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out for add, borrow for subtract; 0 for bitwise codes |

## Verification
The block holds no state, so an internal fault can only be a wrong combinational path. Such a fault shows at the ports in the same evaluation as the input pattern that exercises it. The likely faults are a carry-in or operand inversion missing on subtract, a borrow reported with the wrong polarity, an overflow built from the wrong sign bits, or a flag that leaks through on a bitwise code. Each of these produces a wrong result or flag bit only for certain operand values. A narrow instance is therefore swept over every operand pair under every function code, and a default-width instance is driven at the sign and carry boundaries.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;
endpackage

// File: rtl/alu_cc_addsub.sv
module alu_cc_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             do_sub,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_flag,
  output logic             ovf_flag
);
  localparam int MSB = WIDTH - 1;

  // Extended adder: base + addend + carry-in, with the carry out in the top bit.
  function automatic logic [WIDTH:0] add_ext(input logic [WIDTH-1:0] base,
                                             input logic [WIDTH-1:0] addend,
                                             input logic cin);
    return {1'b0, base} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
  endfunction

  // Signed overflow: both inputs share a sign that the sum does not.
  function automatic logic sign_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   ext_sum;
  logic             cout_raw;

  always_comb begin
    addend     = do_sub ? ~opnd_a : opnd_a;
    ext_sum    = add_ext(opnd_b, addend, do_sub);
    sum        = ext_sum[MSB:0];
    cout_raw   = ext_sum[WIDTH];
    carry_flag = do_sub ? ~cout_raw : cout_raw;
    ovf_flag   = sign_ovf(opnd_b[MSB], addend[MSB], sum[MSB]);

    if (!$isunknown({do_sub, opnd_a, opnd_b})) begin
      AST_ADD_MIXED_SIGN_NO_OVF: assert (do_sub || (opnd_a[MSB] == opnd_b[MSB]) || !ovf_flag); // R7
      AST_SUB_SAME_SIGN_NO_OVF: assert (!do_sub || (opnd_a[MSB] != opnd_b[MSB]) || !ovf_flag); // R8
      AST_SUB_EQUAL_NO_BORROW: assert (!do_sub || (opnd_a != opnd_b) || (sum == '0 && !carry_flag)); // R6
      AST_ADD_ZERO_OPND_NO_CARRY: assert (do_sub || (opnd_a != '0) || (sum == opnd_b && !carry_flag)); // R5
    end
  end
endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic #(
  parameter int WIDTH = 32
) (
  input  logic             sel_xor,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] bits_out
);
  always_comb begin
    bits_out = sel_xor ? (opnd_a ^ opnd_b) : (opnd_a & opnd_b);

    if (!$isunknown({sel_xor, opnd_a, opnd_b})) begin
      AST_AND_SUBSET: assert (sel_xor || ((bits_out & ~opnd_a) == '0 && (bits_out & ~opnd_b) == '0)); // R3
      AST_XOR_INVERTIBLE: assert (!sel_xor || ((bits_out ^ opnd_b) == opnd_a)); // R3
    end
  end
endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags #(
  parameter int WIDTH = 32
) (
  input  alu_cc_pkg::alu_fn_e fn,
  input  logic [WIDTH-1:0]    arith_res,
  input  logic                arith_cf,
  input  logic                arith_of,
  input  logic [WIDTH-1:0]    logic_res,
  output logic [WIDTH-1:0]    res_out,
  output logic                zf,
  output logic                cf,
  output logic                of
);
  import alu_cc_pkg::*;

  logic is_arith;

  always_comb begin
    is_arith = (fn == FN_ADD) || (fn == FN_SUB);
    res_out  = is_arith ? arith_res : logic_res;
    cf       = is_arith & arith_cf;
    of       = is_arith & arith_of;
    zf       = ~|res_out;

    if (!$isunknown({fn, arith_res, arith_cf, arith_of, logic_res})) begin
      AST_LOGIC_FLAGS_CLEAR: assert (is_arith || (!of && !cf)); // R9
      AST_ZERO_MATCHES_SOURCE: assert (zf == (is_arith ? (arith_res == '0) : (logic_res == '0))); // R4
    end
  end
endmodule

// File: rtl/alu_cc.sv
module alu_cc #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fn_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             flag_ovf,
  output logic             flag_zero,
  output logic             flag_carry
);
  import alu_cc_pkg::*;

  alu_fn_e          fn;
  logic [WIDTH-1:0] arith_res;
  logic             arith_cf;
  logic             arith_of;
  logic [WIDTH-1:0] logic_res;

  assign fn = alu_fn_e'(fn_sel);

  alu_cc_addsub #(.WIDTH(WIDTH)) u_addsub (
    .do_sub    (fn == FN_SUB),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sum       (arith_res),
    .carry_flag(arith_cf),
    .ovf_flag  (arith_of)
  );

  alu_cc_logic #(.WIDTH(WIDTH)) u_logic (
    .sel_xor (fn == FN_XOR),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .bits_out(logic_res)
  );

  alu_cc_flags #(.WIDTH(WIDTH)) u_flags (
    .fn       (fn),
    .arith_res(arith_res),
    .arith_cf (arith_cf),
    .arith_of (arith_of),
    .logic_res(logic_res),
    .res_out  (result),
    .zf       (flag_zero),
    .cf       (flag_carry),
    .of       (flag_ovf)
  );

  always_comb begin
    if (!$isunknown({fn_sel, opnd_a, opnd_b})) begin
      AST_ZERO_OPERANDS_ZERO: assert ((opnd_a != '0) || (opnd_b != '0) || (flag_zero && !flag_carry && !flag_ovf)); // R10
    end
  end
endmodule

// File: tb/alu_cc_bench.sv
module alu_cc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [1:0]    n_fn, w_fn;
  logic [NW-1:0] n_a, n_b, n_res;
  logic [WW-1:0] w_a, w_b, w_res;
  logic n_of, n_zf, n_cf, w_of, w_zf, w_cf;

  alu_cc #(.WIDTH(NW)) u_alu_cc (
    .fn_sel(n_fn), .opnd_a(n_a), .opnd_b(n_b), .result(n_res),
    .flag_ovf(n_of), .flag_zero(n_zf), .flag_carry(n_cf)
  );

  alu_cc #(.WIDTH(WW)) u_alu_cc_wide (
    .fn_sel(w_fn), .opnd_a(w_a), .opnd_b(w_b), .result(w_res),
    .flag_ovf(w_of), .flag_zero(w_zf), .flag_carry(w_cf)
  );

  // Arithmetic reference model: returns {of, zf, cf, result[31:0]}.
  function automatic logic [34:0] ref_alu(input int w, input int fn,
                                          input longint ua, input longint ub);
    longint m = (longint'(1) << w);
    longint half = m / 2;
    longint sa = (ua >= half) ? ua - m : ua;
    longint sb = (ub >= half) ? ub - m : ub;
    longint r = 0, s = 0;
    logic of = 1'b0, cf = 1'b0;
    case (fn)
      0: begin r = (ua + ub) % m; cf = (ua + ub) >= m; s = sa + sb; of = (s >= half) || (s < -half); end
      1: begin r = (ub - ua + m) % m; cf = ub < ua; s = sb - sa; of = (s >= half) || (s < -half); end
      2: r = ua & ub;
      default: r = ua ^ ub;
    endcase
    return {of, (r == 0), cf, r[31:0]};
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic string res_tag(input int fn);
    case (fn)
      0: return "R1 add result";
      1: return "R2 sub result";
      default: return "R3 logic result";
    endcase
  endfunction

  task automatic check_all(input int w, input int fn, input longint ua, input longint ub,
                           input longint res, input logic of, input logic zf, input logic cf);
    logic [34:0] e = ref_alu(w, fn, ua, ub);
    check(res_tag(fn), res, longint'(e[31:0]));
    check("R4 zero flag", longint'(zf), longint'(e[33]));
    case (fn)
      0: begin check("R5 add carry", longint'(cf), longint'(e[32])); check("R7 add overflow", longint'(of), longint'(e[34])); end
      1: begin check("R6 sub borrow", longint'(cf), longint'(e[32])); check("R8 sub overflow", longint'(of), longint'(e[34])); end
      default: begin check("R9 logic carry", longint'(cf), 0); check("R9 logic overflow", longint'(of), 0); end
    endcase
  endtask

  task automatic wide_case(input int fn, input logic [WW-1:0] a, input logic [WW-1:0] b);
    @(posedge clk);
    w_fn = fn[1:0]; w_a = a; w_b = b;
    @(negedge clk);
    check_all(WW, fn, longint'(a), longint'(b), longint'(w_res), w_of, w_zf, w_cf);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_fn = 2'd0; n_a = '0; n_b = '0;
    w_fn = 2'd0; w_a = '0; w_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: zero operands give zero result and only ZF set (R4, R10).
    check("R4 reset zero flag", longint'(n_zf), 1);
    check("R10 reset result", longint'(n_res), 0);
    check("R10 reset carry", longint'(n_cf), 0);

    // Exhaustive narrow sweep over every function code and operand pair.
    for (int fn = 0; fn < 4; fn++)
      for (int a = 0; a < (1 << NW); a++)
        for (int b = 0; b < (1 << NW); b++) begin
          @(posedge clk);
          n_fn = fn[1:0]; n_a = a[NW-1:0]; n_b = b[NW-1:0];
          @(negedge clk);
          check_all(NW, fn, longint'(a), longint'(b), longint'(n_res), n_of, n_zf, n_cf);
        end

    // R10: outputs change between clock edges with no edge in between.
    @(negedge clk);
    n_fn = 2'd0; n_a = 4'd3; n_b = 4'd4;
    #1 check("R10 comb update", longint'(n_res), 7);
    n_fn = 2'd1;
    #1 check("R10 comb update", longint'(n_res), 1);
    n_a = 4'd4;
    #1 check("R10 comb zero", longint'(n_zf), 1);

    // Default-width boundary cases.
    wide_case(0, 32'h0000_0001, 32'h7FFF_FFFF);
    wide_case(0, 32'h0000_0001, 32'hFFFF_FFFF);
    wide_case(0, 32'h8000_0000, 32'h8000_0000);
    wide_case(0, 32'h1234_5678, 32'h0F0F_0F0F);
    wide_case(1, 32'h0000_0001, 32'h0000_0000);
    wide_case(1, 32'h0000_0001, 32'h8000_0000);
    wide_case(1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    wide_case(1, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    wide_case(2, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    wide_case(2, 32'hFFFF_FFFF, 32'h8000_0001);
    wide_case(3, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
    wide_case(3, 32'hFFFF_FFFF, 32'h0000_0000);

    finish_run();
  end
endmodule